// File: doc/BRIEF.md
# Flash Wake-Up and Standby Sequencer

This block sits on the host side of a serial flash link. It runs after power-on or a host reset, before anything else may talk to the flash. It uses a transaction port to drive an external SPI shift engine: it requests a transfer with a one-cycle pulse and takes the result back on a done pulse. The first thing it asks for is the identification bytes. If the returned ID is valid, the flash is awake and the block reports ready.

A flash may have been left in its deep power-down state by an earlier session. While in that state it answers nothing except the release command. For that reason, an ID that reads back as all zeros, all ones, or a value other than the expected one is taken as a sign that the flash is asleep. The block then sends the release command, waits a settling time set at a port, and reads the ID again. It makes a bounded number of such attempts. When they run out, it raises a failure flag and stays in that state until reset.

From the ready state, a standby request parks the link. Chip select is held high, the host's outgoing data line is driven low, and the pull-down on the incoming data line is switched on, so that neither line floats. Dropping the request releases these pin overrides and runs a full ID check again before ready returns.

Top module: `flash_wake_seq`

## Requirements
- R1: After reset, `ready`, `fail` and all three pin overrides are low. The first transfer requested is the ID read: opcode 0x9F with `spi_rx_len` equal to ID_BYTES (3 by default).
- R2: An ID read whose data equals EXP_ID sets `ready` on the cycle after `spi_done`, and no release command is sent.
- R3: After an invalid ID read, if the attempt budget is not used up, the next transfer is the release command: opcode 0xAB with `spi_rx_len` 0.
- R4: After the release transfer completes, the repeated ID read is requested max(`wait_cycles`, 1) clock cycles after the edge that accepts its `spi_done`.
- R5: An all-zero response, an all-ones response and a response that differs from EXP_ID are each treated as invalid.
- R6: If an ID read is invalid after MAX_WAKE release commands, `fail` rises, `ready` stays low, and no further transfer is requested until reset. `standby_req` has no effect in this state.
- R7: While ready, raising `standby_req` drops `ready` one cycle later. One cycle after that, `cs_hold_hi`, `mosi_drive_lo` and `miso_pull_lo` go high, and they stay high with no transfer requested while the request holds.
- R8: Dropping `standby_req` releases the three overrides before any transfer. A new ID check then runs with a fresh budget of MAX_WAKE release attempts, and `ready` is reported only after that check succeeds.
- R9: `spi_req` is a single-cycle pulse, and no new transfer is requested while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_cycles | input | WAIT_W | Settling time after the release command, in clock cycles |
| standby_req | input | 1 | Level request to park the link in standby |
| spi_req | output | 1 | One-cycle transfer request to the shift engine |
| spi_opcode | output | 8 | Command byte for the requested transfer |
| spi_rx_len | output | LEN_W | Number of response bytes to collect |
| spi_done | input | 1 | One-cycle completion pulse from the shift engine |
| spi_rx_data | input | ID_W | Collected response, first byte in the top bits |
| ready | output | 1 | Flash confirmed awake; other accesses may proceed |
| fail | output | 1 | Wake-up attempts exhausted; held until reset |
| cs_hold_hi | output | 1 | Force chip select high |
| mosi_drive_lo | output | 1 | Drive the outgoing data line low |
| miso_pull_lo | output | 1 | Enable the pull-down on the incoming data line |

## Verification
The bench builds the block with its default parameters: a 3-byte ID, MAX_WAKE of 2 and a 16-bit settling counter. With a budget of two, one test can use up every release attempt on the way to ready, while another makes a third bad read reach the failure state. The bench also drives `wait_cycles` to 0, 1 and 5. This covers the clamp to one cycle as well as an ordinary settling window.

// File: rtl/flash_wake_pkg.sv
package flash_wake_pkg;

  localparam logic [7:0] OP_READ_ID = 8'h9F;
  localparam logic [7:0] OP_RELEASE = 8'hAB;

  typedef enum logic [3:0] {
    ST_BOOT      = 4'd0,
    ST_ID_REQ    = 4'd1,
    ST_ID_WAIT   = 4'd2,
    ST_WAKE_REQ  = 4'd3,
    ST_WAKE_WAIT = 4'd4,
    ST_SETTLE    = 4'd5,
    ST_READY     = 4'd6,
    ST_PARKED    = 4'd7,
    ST_FAIL      = 4'd8
  } seq_state_t;

  // Mask covering the low nbits of a 64-bit word.
  function automatic logic [63:0] width_mask(input int unsigned nbits);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < nbits);
    return m;
  endfunction

  // An ID is accepted only if it is neither blank pattern and equals the expected value.
  function automatic logic id_acceptable(input logic [63:0] got,
                                         input logic [63:0] want,
                                         input int unsigned nbits);
    logic [63:0] m;
    logic [63:0] g;
    m = width_mask(nbits);
    g = got & m;
    return (g != 64'd0) && (g != m) && (g == (want & m));
  endfunction

endpackage

// File: rtl/fw_id_judge.sv
module fw_id_judge #(
  parameter int unsigned ID_W = 24,
  parameter logic [ID_W-1:0] EXP_ID = '0
) (
  input  logic [ID_W-1:0] rx_id,
  output logic            id_good
);
  import flash_wake_pkg::*;

  always_comb id_good = id_acceptable(64'(rx_id), 64'(EXP_ID), ID_W);

endmodule

// File: rtl/fw_wait_timer.sv
module fw_wait_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = (cnt <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && !expire)   cnt <= cnt - W'(1);
  end

endmodule

// File: rtl/fw_pin_park.sv
module fw_pin_park (
  input  logic clk,
  input  logic rst_n,
  input  logic park,
  output logic cs_hold_hi,
  output logic mosi_drive_lo,
  output logic miso_pull_lo
);
  logic park_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) park_q <= 1'b0;
    else        park_q <= park;
  end

  assign cs_hold_hi    = park_q;
  assign mosi_drive_lo = park_q;
  assign miso_pull_lo  = park_q;

endmodule

// File: rtl/flash_wake_seq.sv
module flash_wake_seq #(
  parameter int unsigned ID_BYTES = 3,
  parameter int unsigned ID_W     = 8 * ID_BYTES,
  parameter int unsigned LEN_W    = $clog2(ID_BYTES + 1),
  parameter logic [ID_W-1:0] EXP_ID = 24'hC22017,
  parameter int unsigned MAX_WAKE = 2,
  parameter int unsigned WAIT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic              standby_req,
  output logic              spi_req,
  output logic [7:0]        spi_opcode,
  output logic [LEN_W-1:0]  spi_rx_len,
  input  logic              spi_done,
  input  logic [ID_W-1:0]   spi_rx_data,
  output logic              ready,
  output logic              fail,
  output logic              cs_hold_hi,
  output logic              mosi_drive_lo,
  output logic              miso_pull_lo
);
  import flash_wake_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_WAKE + 2);

  seq_state_t state, state_nx;
  logic [CNT_W-1:0] wake_cnt;

  // Named internal events
  logic id_good;
  logic id_bad_evt;
  logic wake_done_evt;
  logic budget_spent;
  logic settle_expire;

  fw_id_judge #(.ID_W(ID_W), .EXP_ID(EXP_ID)) u_judge (
    .rx_id   (spi_rx_data),
    .id_good (id_good)
  );

  assign id_bad_evt    = (state == ST_ID_WAIT) && spi_done && !id_good;
  assign wake_done_evt = (state == ST_WAKE_WAIT) && spi_done;
  assign budget_spent  = (wake_cnt == CNT_W'(MAX_WAKE));

  fw_wait_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_done_evt),
    .load_val (wait_cycles),
    .run      (state == ST_SETTLE),
    .expire   (settle_expire)
  );

  fw_pin_park u_park (
    .clk           (clk),
    .rst_n         (rst_n),
    .park          (state == ST_PARKED),
    .cs_hold_hi    (cs_hold_hi),
    .mosi_drive_lo (mosi_drive_lo),
    .miso_pull_lo  (miso_pull_lo)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_BOOT:      state_nx = ST_ID_REQ;
      ST_ID_REQ:    state_nx = ST_ID_WAIT;
      ST_ID_WAIT:   if (spi_done) begin
                      if (id_good)           state_nx = ST_READY;
                      else if (budget_spent) state_nx = ST_FAIL;
                      else                   state_nx = ST_WAKE_REQ;
                    end
      ST_WAKE_REQ:  state_nx = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (spi_done) state_nx = ST_SETTLE;
      ST_SETTLE:    if (settle_expire) state_nx = ST_ID_REQ;
      ST_READY:     if (standby_req) state_nx = ST_PARKED;
      ST_PARKED:    if (!standby_req) state_nx = ST_BOOT;
      ST_FAIL:      state_nx = ST_FAIL;
      default:      state_nx = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_BOOT;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wake_cnt <= '0;
    else if (state == ST_BOOT)     wake_cnt <= '0;
    else if (state == ST_WAKE_REQ) wake_cnt <= wake_cnt + CNT_W'(1);
  end

  assign spi_req    = (state == ST_ID_REQ) || (state == ST_WAKE_REQ);
  assign spi_opcode = (state == ST_WAKE_REQ) ? OP_RELEASE : OP_READ_ID;
  assign spi_rx_len = (state == ST_WAKE_REQ) ? '0 : LEN_W'(ID_BYTES);
  assign ready      = (state == ST_READY);
  assign fail       = (state == ST_FAIL);

endmodule

// File: rtl/flash_wake_seq_chk.sv
module flash_wake_seq_chk #(
  parameter int unsigned WAIT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_req,
  input logic [7:0]        spi_opcode,
  input logic              spi_done,
  input logic              id_good,
  input logic              ready,
  input logic              fail,
  input logic              cs_hold_hi,
  input logic [WAIT_W-1:0] wait_cycles
);
  import flash_wake_pkg::*;

  logic [7:0]      last_op;
  logic            busy, need_wake, armed, seen_req;
  logic [WAIT_W:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_READ_ID; busy <= 1'b0; need_wake <= 1'b0;
      armed <= 1'b0; seen_req <= 1'b0; gap <= '0;
    end else begin
      if (spi_req) begin
        last_op <= spi_opcode; busy <= 1'b1; seen_req <= 1'b1;
        need_wake <= 1'b0; armed <= 1'b0;
      end else if (spi_done) begin
        busy <= 1'b0;
        if (last_op == OP_READ_ID && !id_good) need_wake <= 1'b1;
        if (last_op == OP_RELEASE) begin armed <= 1'b1; gap <= '0; end
      end else if (armed && !(&gap)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  assert_first_is_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !seen_req) |-> spi_opcode == OP_READ_ID);
  assert_ready_needs_good_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(spi_done && id_good));
  assert_wake_after_bad_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && need_wake) |-> spi_opcode == OP_RELEASE);
  assert_settle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && armed) |-> gap >= {1'b0, wait_cycles});
  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);
  assert_fail_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!spi_req && !ready));
  assert_no_xfer_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hold_hi |-> !spi_req);
  assert_ready_unparked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !cs_hold_hi);
  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_req);

endmodule

bind flash_wake_seq flash_wake_seq_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_req     (spi_req),
  .spi_opcode  (spi_opcode),
  .spi_done    (spi_done),
  .id_good     (id_good),
  .ready       (ready),
  .fail        (fail),
  .cs_hold_hi  (cs_hold_hi),
  .wait_cycles (wait_cycles)
);

// File: tb/flash_wake_seq_test.sv
`timescale 1ns/1ps
module flash_wake_seq_test;
  localparam int unsigned WAIT_W = 16;
  localparam logic [23:0] GOOD_ID = 24'hC22017;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WAIT_W-1:0] wait_cycles = '0;
  logic standby_req = 1'b0;
  logic spi_req;
  logic [7:0] spi_opcode;
  logic [1:0] spi_rx_len;
  logic spi_done = 1'b0;
  logic [23:0] spi_rx_data = '0;
  logic ready, fail, cs_hold_hi, mosi_drive_lo, miso_pull_lo;

  flash_wake_seq uut (
    .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .standby_req(standby_req),
    .spi_req(spi_req), .spi_opcode(spi_opcode), .spi_rx_len(spi_rx_len),
    .spi_done(spi_done), .spi_rx_data(spi_rx_data), .ready(ready), .fail(fail),
    .cs_hold_hi(cs_hold_hi), .mosi_drive_lo(mosi_drive_lo), .miso_pull_lo(miso_pull_lo)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Flash and shift-engine model state
  bit          sleeping = 1'b0;
  int          wakes_left = 0;
  logic [23:0] sleep_pat = '0;
  logic [23:0] awake_id = GOOD_ID;
  int n_id = 0, n_wake = 0, op_n = 0, gap_meas = 0, overlap = 0, parked_req = 0;
  logic [7:0] op_log [0:15];
  logic [1:0] len_log [0:15];
  bit busy = 1'b0;
  int lat = 0;
  logic [7:0] cur_op = '0;
  logic [7:0] prev_op = '0;
  int t_wake_done = 0;

  initial begin
    forever begin
      @(negedge clk);
      spi_done = 1'b0;
      if (!rst_n) begin
        busy = 1'b0;
      end else if (busy) begin
        if (spi_req) overlap++;
        if (lat == 0) begin
          spi_done = 1'b1;
          busy = 1'b0;
          if (cur_op == 8'h9F) spi_rx_data = sleeping ? sleep_pat : awake_id;
          else begin
            spi_rx_data = '0;
            t_wake_done = cyc;
            if (wakes_left > 0) wakes_left--;
            if (wakes_left == 0) sleeping = 1'b0;
          end
        end else lat--;
      end else if (spi_req) begin
        if (cs_hold_hi) parked_req++;
        busy = 1'b1; lat = 2; cur_op = spi_opcode;
        if (op_n < 16) begin op_log[op_n] = spi_opcode; len_log[op_n] = spi_rx_len; end
        op_n++;
        if (spi_opcode == 8'h9F) begin
          n_id++;
          if (prev_op == 8'hAB) gap_meas = cyc - t_wake_done;
        end else n_wake++;
        prev_op = spi_opcode;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_id = 0; n_wake = 0; op_n = 0; gap_meas = 0; overlap = 0; parked_req = 0;
    prev_op = '0;
  endtask

  task automatic do_reset(input bit sl, input int wakes, input logic [23:0] pat,
                          input logic [23:0] aid, input int wc);
    @(negedge clk);
    rst_n = 1'b0; standby_req = 1'b0;
    sleeping = sl; wakes_left = wakes; sleep_pat = pat; awake_id = aid;
    wait_cycles = WAIT_W'(wc);
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_settled();
    for (int i = 0; i < 2000; i++) begin
      if (ready || fail) break;
      @(negedge clk);
    end
  endtask

  function automatic int exp_gap(input int wc);
    return ((wc < 1) ? 1 : wc) + 1;
  endfunction

  task automatic t_reset_and_awake();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", ready, 0);
    chk("R1 fail in reset", fail, 0);
    chk("R1 pins in reset", {cs_hold_hi, mosi_drive_lo, miso_pull_lo}, 0);
    do_reset(0, 0, 24'h0, GOOD_ID, 4);
    wait_settled();
    chk("R1 first opcode", op_log[0], 8'h9F);
    chk("R1 first rx length", len_log[0], 3);
    chk("R2 ready on good id", ready, 1);
    chk("R2 no release sent", n_wake, 0);
    chk("R2 single id read", n_id, 1);
  endtask

  task automatic t_zero_pattern();
    do_reset(1, 1, 24'h000000, GOOD_ID, 5);
    wait_settled();
    chk("R3 second opcode release", op_log[1], 8'hAB);
    chk("R3 release rx length", len_log[1], 0);
    chk("R5 zero pattern reread", op_log[2], 8'h9F);
    chk("R4 settle gap wc=5", gap_meas, exp_gap(5));
    chk("R2 ready after wake", ready, 1);
  endtask

  task automatic t_ones_pattern();
    do_reset(1, 1, 24'hFFFFFF, GOOD_ID, 1);
    wait_settled();
    chk("R5 ones pattern needs wake", n_wake, 1);
    chk("R4 settle gap wc=1", gap_meas, exp_gap(1));
    chk("R5 ready after ones", ready, 1);
  endtask

  task automatic t_two_wakes();
    do_reset(1, 2, 24'h000000, GOOD_ID, 0);
    wait_settled();
    chk("R4 settle gap wc=0", gap_meas, exp_gap(0));
    chk("R3 full budget used", n_wake, 2);
    chk("R6 ready within budget", {ready, fail}, 2'b10);
    chk("R9 no overlapping request", overlap, 0);
  endtask

  task automatic t_mismatch_fail();
    int ops_at_fail;
    do_reset(0, 0, 24'h0, 24'hC22018, 3);
    wait_settled();
    chk("R5 mismatch id reads", n_id, 3);
    chk("R6 releases before fail", n_wake, 2);
    chk("R6 fail flag", {ready, fail}, 2'b01);
    ops_at_fail = op_n;
    standby_req = 1'b1;
    repeat (40) @(negedge clk);
    chk("R6 standby ignored in fail", {cs_hold_hi, mosi_drive_lo, miso_pull_lo}, 0);
    chk("R6 no request after fail", op_n, ops_at_fail);
    chk("R6 fail held", fail, 1);
    standby_req = 1'b0;
  endtask

  task automatic t_standby();
    int ops_before;
    do_reset(1, 2, 24'h000000, GOOD_ID, 2);
    wait_settled();
    chk("R8 ready before standby", ready, 1);
    standby_req = 1'b1;
    @(negedge clk);
    chk("R7 ready drops", ready, 0);
    @(negedge clk);
    chk("R7 pins parked", {cs_hold_hi, mosi_drive_lo, miso_pull_lo}, 3'b111);
    ops_before = op_n;
    sleeping = 1'b1; wakes_left = 2; sleep_pat = 24'h000000;
    repeat (20) @(negedge clk);
    chk("R7 pins held", {cs_hold_hi, mosi_drive_lo, miso_pull_lo}, 3'b111);
    chk("R7 no request parked", op_n, ops_before);
    standby_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 pins released", {cs_hold_hi, mosi_drive_lo, miso_pull_lo}, 3'b000);
    wait_settled();
    chk("R8 fresh check opcode", op_log[ops_before], 8'h9F);
    chk("R8 fresh wake budget", n_wake, 4);
    chk("R8 ready after recheck", {ready, fail}, 2'b10);
    chk("R7 no request while parked", parked_req, 0);
  endtask

  initial begin
    t_reset_and_awake();
    t_zero_pattern();
    t_ones_pattern();
    t_two_wakes();
    t_mismatch_fail();
    t_standby();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule